// File: doc/BRIEF.md
# Triadic Fused-Operation Crypto ALU

A 32-bit execution unit for cipher kernels. Each instruction reads three source operands (A, B, C) and produces one result. Most instructions chain two primitive operations into a single issue. The first primitive combines A with B, and the second combines that intermediate value with C. This lets pairs such as add-then-xor or and-then-rotate finish in one cycle. The unit can also run a single long operation: a 32-bit multiply, or a multiply modulo 65537 of the kind used by 16-bit block ciphers.

Substitution-table reads are not stored inside the unit. When an instruction names a table lookup, the unit raises a request carrying an 8-bit index on an external port. It stalls until the table owner acknowledges with the data, then finishes the chained operation. A busy output tells the issuing logic when a new instruction cannot be accepted.

Top module: `triad_alu`

## Requirements
- R1: The opcode is 9 bits: form in [8:6], first-slot operation in [5:3], second-slot operation in [2:0]. Form 1 is short-then-tiny, form 2 is tiny-then-short, and form 3 is tiny-then-tiny. In each pair form the result is second(first(A,B),C), delivered with outValid in the cycle after issue.
- R2: The tiny operation codes are 1 = xor, 2 = and, 3 = increment the first input, 4 = replicate bit 7 of the first input into bits 31:8, and any other code = pass the first input.
- R3: The short operation codes are 1 = add, 2 = subtract (first minus second), 3 = rotate left, 4 = rotate right, 5 = table lookup, and any other code = pass the first input. Rotates use only the low 5 bits of the second input.
- R4: Form 4 returns the low 32 bits of A*B. outValid rises in the third cycle counted from the issue cycle.
- R5: Form 5 multiplies A[15:0] by B[15:0] modulo 65537, with an input of 0 standing for 65536. It returns the 16-bit residue zero-extended, with 65536 written as 0, under the same 3-cycle timing as R4.
- R6: busy is high while a long or lookup instruction is in flight. inValid is ignored while busy is high and produces no result.
- R7: A lookup in the short slot raises lkReq with lkIdx. The index is A[7:0] in form 1 and the first-slot result [7:0] in form 2. lkReq and lkIdx stay steady until lkAck, and the result, using lkData as the lookup value, is delivered in the cycle after the acknowledging edge.
- R8: Forms 0, 6 and 7 are no-operations that return A with the single-cycle timing of R1.
- R9: After reset, result is 0 and outValid, busy and lkReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction issue strobe |
| opcode | input | 9 | Form and slot operation codes |
| opA | input | 32 | Source operand A |
| opB | input | 32 | Source operand B |
| opC | input | 32 | Source operand C |
| busy | output | 1 | Unit cannot accept an issue |
| outValid | output | 1 | Result valid pulse |
| result | output | 32 | Instruction result |
| lkReq | output | 1 | Table lookup request |
| lkIdx | output | 8 | Table lookup index |
| lkAck | input | 1 | Table lookup response valid |
| lkData | input | 32 | Table lookup response data |

## Verification
The bench builds the unit with the default three-cycle long-operation latency, so the product stage and the reduction stage each get one exact edge. Those edges are checked against the cycle counts measured at the ports. A table responder acknowledges after a random delay of zero to three cycles. This covers both immediate and held lookup requests in either slot. Random opcodes reach every form and every slot code, including the unused ones. Directed cases cover the zero-means-65536 corners of the modular multiply, rotates by amounts of 32 or more, sign replication and increment wraparound.

// File: rtl/triad_alu_pkg.sv
package triad_alu_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 8;
  localparam int SEXT_BIT = 7;
  localparam int ROT_W    = $clog2(DATA_W);
  localparam int CODE_W   = 3;
  localparam int OP_W     = 3 * CODE_W;
  localparam int HALF_W   = 16;
  localparam int PROD_W   = 2 * HALF_W + 1;

  localparam logic [CODE_W-1:0] FORM_ST     = 3'd1;
  localparam logic [CODE_W-1:0] FORM_TS     = 3'd2;
  localparam logic [CODE_W-1:0] FORM_TT     = 3'd3;
  localparam logic [CODE_W-1:0] FORM_MUL    = 3'd4;
  localparam logic [CODE_W-1:0] FORM_MULMOD = 3'd5;

  localparam logic [CODE_W-1:0] T_XOR  = 3'd1;
  localparam logic [CODE_W-1:0] T_AND  = 3'd2;
  localparam logic [CODE_W-1:0] T_INC  = 3'd3;
  localparam logic [CODE_W-1:0] T_SEXT = 3'd4;

  localparam logic [CODE_W-1:0] S_ADD  = 3'd1;
  localparam logic [CODE_W-1:0] S_SUB  = 3'd2;
  localparam logic [CODE_W-1:0] S_ROTL = 3'd3;
  localparam logic [CODE_W-1:0] S_ROTR = 3'd4;
  localparam logic [CODE_W-1:0] S_LOOK = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MUL} alu_state_e;

  typedef struct packed {
    logic capture;   // latch operands and opcode
    logic useHeld;   // datapath works on latched operands
    logic loadPair;  // register chained-pair result
    logic loadProd;  // register raw product
    logic loadMul;   // register reduced long result
  } alu_ctl_t;

  function automatic logic [DATA_W-1:0] tinyOp(input logic [CODE_W-1:0] code,
                                               input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    case (code)
      T_XOR:   return x ^ y;
      T_AND:   return x & y;
      T_INC:   return x + 1'b1;
      T_SEXT:  return {{(DATA_W-SEXT_BIT-1){x[SEXT_BIT]}}, x[SEXT_BIT:0]};
      default: return x;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] shortOp(input logic [CODE_W-1:0] code,
                                                input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y,
                                                input logic [DATA_W-1:0] lk);
    logic [2*DATA_W-1:0] dbl;
    dbl = '0;
    case (code)
      S_ADD:  return x + y;
      S_SUB:  return x - y;
      S_ROTL: begin
        dbl = {x, x} << y[ROT_W-1:0];
        return dbl[2*DATA_W-1:DATA_W];
      end
      S_ROTR: begin
        dbl = {x, x} >> y[ROT_W-1:0];
        return dbl[DATA_W-1:0];
      end
      S_LOOK:  return lk;
      default: return x;
    endcase
  endfunction
endpackage

// File: rtl/triad_alu_ctl.sv
module triad_alu_ctl
  import triad_alu_pkg::*;
#(
  parameter int MulCycles = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] opcode,
  input  logic            lkAck,
  output alu_ctl_t        ctl,
  output logic            busy,
  output logic            outValid,
  output logic            lkReq
);
  localparam int CNT_W = $clog2(MulCycles) + 1;

  alu_state_e state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic [CODE_W-1:0] form, f1, f2;
  logic isLong, hasLook;

  assign form = opcode[3*CODE_W-1:2*CODE_W];
  assign f1   = opcode[2*CODE_W-1:CODE_W];
  assign f2   = opcode[CODE_W-1:0];
  assign isLong  = (form == FORM_MUL) || (form == FORM_MULMOD);
  assign hasLook = ((form == FORM_ST) && (f1 == S_LOOK)) ||
                   ((form == FORM_TS) && (f2 == S_LOOK));

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (inValid) begin
        ctl.capture = 1'b1;
        if (isLong)       stateNext = ST_MUL;
        else if (hasLook) stateNext = ST_LOOK;
        else              ctl.loadPair = 1'b1;
      end
      ST_LOOK: begin
        ctl.useHeld = 1'b1;
        if (lkAck) begin
          ctl.loadPair = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: begin
        ctl.useHeld  = 1'b1;
        ctl.loadProd = (cnt == '0);
        if (cnt == CNT_W'(MulCycles - 2)) begin
          ctl.loadMul = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      outValid <= 1'b0;
    end else begin
      state    <= stateNext;
      outValid <= ctl.loadPair | ctl.loadMul;
      if (state == ST_MUL) cnt <= cnt + 1'b1;
      else                 cnt <= '0;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign lkReq = (state == ST_LOOK);
endmodule

// File: rtl/triad_alu_dp.sv
module triad_alu_dp
  import triad_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  alu_ctl_t          ctl,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [DATA_W-1:0] lkData,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [DATA_W-1:0] result
);
  logic [OP_W-1:0]   opQ, opS;
  logic [DATA_W-1:0] aQ, bQ, cQ, aS, bS, cS;
  logic [DATA_W-1:0] mid, pair, mulOut;
  logic [CODE_W-1:0] form, f1, f2, formQ;
  logic [PROD_W-1:0] prodD, prodQ;
  logic [HALF_W:0]   xe, ye;
  logic [HALF_W-1:0] lo;
  logic [HALF_W:0]   hi;
  logic [HALF_W+1:0] diff;

  assign opS = ctl.useHeld ? opQ : opcode;
  assign aS  = ctl.useHeld ? aQ  : opA;
  assign bS  = ctl.useHeld ? bQ  : opB;
  assign cS  = ctl.useHeld ? cQ  : opC;
  assign form = opS[3*CODE_W-1:2*CODE_W];
  assign f1   = opS[2*CODE_W-1:CODE_W];
  assign f2   = opS[CODE_W-1:0];

  always_comb begin
    case (form)
      FORM_ST: begin
        mid  = shortOp(f1, aS, bS, lkData);
        pair = tinyOp(f2, mid, cS);
      end
      FORM_TS: begin
        mid  = tinyOp(f1, aS, bS);
        pair = shortOp(f2, mid, cS, lkData);
      end
      FORM_TT: begin
        mid  = tinyOp(f1, aS, bS);
        pair = tinyOp(f2, mid, cS);
      end
      default: begin
        mid  = aS;
        pair = aS;
      end
    endcase
  end

  assign lkIdx = (form == FORM_ST) ? aS[IDX_W-1:0] : mid[IDX_W-1:0];

  // long path: product stage from held operands, then reduction stage
  assign formQ = opQ[3*CODE_W-1:2*CODE_W];
  assign xe = {(aQ[HALF_W-1:0] == '0), aQ[HALF_W-1:0]};
  assign ye = {(bQ[HALF_W-1:0] == '0), bQ[HALF_W-1:0]};

  always_comb begin
    logic [2*DATA_W-1:0] full;
    full = aQ * bQ;
    if (formQ == FORM_MULMOD) prodD = PROD_W'(xe * ye);
    else                      prodD = {1'b0, full[DATA_W-1:0]};
  end

  assign lo = prodQ[HALF_W-1:0];
  assign hi = prodQ[PROD_W-1:HALF_W];
  always_comb begin
    diff = {2'b00, lo} - {1'b0, hi};
    if ({1'b0, lo} < hi) diff = diff + ((HALF_W+2)'(1) << HALF_W) + 1'b1;
    if (formQ == FORM_MULMOD) mulOut = DATA_W'(diff[HALF_W-1:0]);
    else                      mulOut = prodQ[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= '0;
      aQ     <= '0;
      bQ     <= '0;
      cQ     <= '0;
      prodQ  <= '0;
      result <= '0;
    end else begin
      if (ctl.capture) begin
        opQ <= opcode;
        aQ  <= opA;
        bQ  <= opB;
        cQ  <= opC;
      end
      if (ctl.loadProd) prodQ <= prodD;
      if (ctl.loadPair)     result <= pair;
      else if (ctl.loadMul) result <= mulOut;
    end
  end
endmodule

// File: rtl/triad_alu.sv
module triad_alu
  import triad_alu_pkg::*;
#(
  parameter int MulCycles = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  output logic              busy,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              lkReq,
  output logic [IDX_W-1:0]  lkIdx,
  input  logic              lkAck,
  input  logic [DATA_W-1:0] lkData
);
  alu_ctl_t ctl;

  triad_alu_ctl #(.MulCycles(MulCycles)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .lkAck(lkAck), .ctl(ctl), .busy(busy), .outValid(outValid), .lkReq(lkReq)
  );

  triad_alu_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opcode(opcode),
    .opA(opA), .opB(opB), .opC(opC), .lkData(lkData),
    .lkIdx(lkIdx), .result(result)
  );
endmodule

// File: rtl/triad_alu_chk.sv
module triad_alu_chk
  import triad_alu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   opcode,
  input logic              busy,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              lkReq,
  input logic [IDX_W-1:0]  lkIdx,
  input logic              lkAck
);
  logic [CODE_W-1:0] form;
  logic issue, longIssue, quickIssue, lastMm;

  assign form       = opcode[3*CODE_W-1:2*CODE_W];
  assign issue      = inValid && !busy;
  assign longIssue  = issue && (form == FORM_MUL || form == FORM_MULMOD);
  assign quickIssue = issue && !(form == FORM_MUL || form == FORM_MULMOD) &&
                      !(form == FORM_ST && opcode[2*CODE_W-1:CODE_W] == S_LOOK) &&
                      !(form == FORM_TS && opcode[CODE_W-1:0] == S_LOOK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      lastMm <= 1'b0;
    else if (issue) lastMm <= (form == FORM_MULMOD);
  end

  // R1
  quick_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    quickIssue |=> outValid && !busy);

  // R6
  long_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    longIssue |=> busy && !outValid);

  // R7
  look_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkReq && !lkAck |=> lkReq && $stable(lkIdx));

  // R6
  look_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |-> busy);

  // R5
  mm_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && lastMm |-> result[DATA_W-1:HALF_W] == '0);
endmodule

bind triad_alu triad_alu_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .busy(busy),
  .outValid(outValid), .result(result), .lkReq(lkReq), .lkIdx(lkIdx), .lkAck(lkAck)
);

// File: tb/triad_alu_bench.sv
module triad_alu_bench;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, lkAck = 1'b0;
  logic [8:0] opcode = '0;
  logic [31:0] opA = '0, opB = '0, opC = '0, lkData = '0;
  logic busy, outValid, lkReq;
  logic [31:0] result;
  logic [7:0] lkIdx;
  int checks = 0, fails = 0, waitCnt = 0, cycles = 0;

  triad_alu u_triad_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .opA(opA),
    .opB(opB), .opC(opC), .busy(busy), .outValid(outValid), .result(result),
    .lkReq(lkReq), .lkIdx(lkIdx), .lkAck(lkAck), .lkData(lkData)
  );

  always #(ClkPeriod/2) clk = ~clk;

  function automatic logic [31:0] tbl(input logic [7:0] i);
    return {i ^ 8'hA5, i, ~i, i + 8'd17};
  endfunction

  function automatic logic [31:0] tinyM(input logic [2:0] k, input logic [31:0] x, y);
    case (k)
      3'd1: return x ^ y;
      3'd2: return x & y;
      3'd3: return x + 32'd1;
      3'd4: return x[7] ? (x | 32'hFFFF_FF00) : (x & 32'h0000_00FF);
      default: return x;
    endcase
  endfunction

  function automatic logic [31:0] shortM(input logic [2:0] k, input logic [31:0] x, y);
    int n;
    n = int'(y % 32);
    case (k)
      3'd1: return x + y;
      3'd2: return x - y;
      3'd3: return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
      3'd4: return (n == 0) ? x : ((x >> n) | (x << (32 - n)));
      3'd5: return tbl(x[7:0]);
      default: return x;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [8:0] op, input logic [31:0] a, b, c);
    longint unsigned xa, xb, p;
    case (op[8:6])
      3'd1: return tinyM(op[2:0], shortM(op[5:3], a, b), c);
      3'd2: return shortM(op[2:0], tinyM(op[5:3], a, b), c);
      3'd3: return tinyM(op[2:0], tinyM(op[5:3], a, b), c);
      3'd4: begin p = longint'(a) * longint'(b); return p[31:0]; end
      3'd5: begin
        xa = (a[15:0] == 0) ? 65536 : a[15:0];
        xb = (b[15:0] == 0) ? 65536 : b[15:0];
        p = (xa * xb) % 65537;
        return (p == 65536) ? 32'd0 : p[31:0];
      end
      default: return a;
    endcase
  endfunction

  function automatic int expLat(input logic [8:0] op);
    if (op[8:6] == 3'd4 || op[8:6] == 3'd5) return 3;
    if ((op[8:6] == 3'd1 && op[5:3] == 3'd5) || (op[8:6] == 3'd2 && op[2:0] == 3'd5)) return 0;
    return 1;
  endfunction

  function automatic string reqOf(input logic [8:0] op);
    if (op[8:6] == 3'd4) return "R4";
    if (op[8:6] == 3'd5) return "R5";
    if (expLat(op) == 0) return "R7";
    if (op[8:6] == 3'd0 || op[8:6] > 3'd5) return "R8";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // table owner: acknowledges after 0..3 cycles
  always @(negedge clk) begin
    if (lkAck) lkAck = 1'b0;
    else if (lkReq) begin
      if (waitCnt == 0) begin
        lkAck = 1'b1;
        lkData = tbl(lkIdx);
        waitCnt = int'($urandom_range(0, 3));
      end else waitCnt--;
    end
  end

  task automatic runOp(input logic [8:0] op, input logic [31:0] a, b, c, input string req);
    int lat;
    @(negedge clk);
    inValid = 1'b1; opcode = op; opA = a; opB = b; opC = c;
    @(negedge clk);
    inValid = 1'b0; opA = $urandom; opB = $urandom; opC = $urandom;
    lat = 1;
    while (!outValid && lat < 50) begin @(negedge clk); lat++; end
    check(req, result, model(op, a, b, c));
    if (expLat(op) != 0) check({req, " latency"}, 32'(lat), 32'(expLat(op)));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    logic [8:0] op;
    logic [31:0] a;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result", result, 32'd0);
    check("R9 flags", {29'd0, outValid, busy, lkReq}, 32'd0);
    rstN = 1'b1;
    // R1 add-xor, and-rotl
    runOp({3'd1, 3'd1, 3'd1}, 32'h1234_5678, 32'h1111_1111, 32'hFFFF_0000, "R1");
    runOp({3'd2, 3'd2, 3'd3}, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'd4, "R1");
    // R2 inc wrap, sign replicate both polarities
    runOp({3'd3, 3'd3, 3'd0}, 32'hFFFF_FFFF, 32'd0, 32'd0, "R2");
    runOp({3'd3, 3'd4, 3'd1}, 32'h0000_0080, 32'd0, 32'h5, "R2");
    runOp({3'd3, 3'd4, 3'd2}, 32'hFFFF_FF7F, 32'd0, 32'hFFFF_FFFF, "R2");
    // R3 rotates use amount mod 32, subtract
    runOp({3'd1, 3'd3, 3'd0}, 32'h8000_0001, 32'd35, 32'd0, "R3");
    runOp({3'd1, 3'd4, 3'd0}, 32'h8000_0001, 32'd32, 32'd0, "R3");
    runOp({3'd2, 3'd0, 3'd2}, 32'd5, 32'd0, 32'd9, "R3");
    // R5 corners: 0 as 65536
    runOp({3'd5, 6'd0}, 32'hABCD_0000, 32'h0000_0000, 32'd0, "R5");
    runOp({3'd5, 6'd0}, 32'h0000_0000, 32'h0000_0001, 32'd0, "R5");
    runOp({3'd5, 6'd0}, 32'h0000_FFFF, 32'h0000_FFFF, 32'd0, "R5");
    // R4 full multiply
    runOp({3'd4, 6'd0}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, "R4");
    // R7 lookups in either slot
    runOp({3'd1, 3'd5, 3'd1}, 32'h0000_01C3, 32'd0, 32'h0F0F_0F0F, "R7");
    runOp({3'd2, 3'd1, 3'd5}, 32'h0000_00F0, 32'h0000_000F, 32'd0, "R7");
    // R8 nop forms
    runOp({3'd7, 3'd2, 3'd1}, 32'hCAFE_BABE, 32'd1, 32'd2, "R8");
    // R6 issue during busy is ignored
    @(negedge clk);
    inValid = 1'b1; opcode = {3'd4, 6'd0}; opA = 32'd3; opB = 32'd7; opC = 32'd0;
    @(negedge clk);
    check("R6 busy", {31'd0, busy}, 32'd1);
    opcode = {3'd1, 3'd1, 3'd0}; opA = 32'd100; opB = 32'd1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check("R6 result", result, 32'd21);
    check("R6 valid", {31'd0, outValid}, 32'd1);
    @(negedge clk);
    check("R6 no extra", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    check("R6 no extra", {31'd0, outValid}, 32'd0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      op = 9'($urandom);
      a = ($urandom_range(0, 4) == 0) ? 32'd0 : $urandom;
      runOp(op, a, $urandom, $urandom, reqOf(op));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule